// File: doc/BRIEF.md
# Serial command receiver with event pulses

This block sits behind a four-wire serial link on which an external controller sends 16-bit command words. The controller drives a serial clock, an active-low select and a data line. The block samples the data line on each rising serial-clock edge while the select is low, most significant bit first. When a word is complete, the block hands it to the system clock domain through a toggle handshake. There it decodes the top four bits as a request code.

Three request codes are recognised. The first is a spin request. Its 12-bit payload holds three 4-bit reel indices, and the block raises `start_spin_o`. The second is a win-amount update and the third is a total-credit update. Both latch the 12-bit payload onto `value_o`, and they raise `is_win_o` or `is_total_o` respectively. Each flag is a pulse of one system cycle. The latched outputs keep their values until the next request of the matching kind.

Top module: `spi_cmd_rx`

## Requirements
- R1: Data is sampled on the rising edge of `sclk_i` only while `cs_ni` is low. The first bit of a word lands in bit 15 and the last in bit 0.
- R2: Raising `cs_ni` before 16 bits have arrived discards the partial word. Serial clock edges seen while `cs_ni` is high are ignored. In both cases no event follows, and the next complete word decodes correctly.
- R3: Each complete 16-bit word produces at most one decoded event in the system domain, within 6 system clock cycles of its 16th rising serial-clock edge.
- R4: Code 4'b0001 (bits 15:12) pulses `start_spin_o`. On the same edge it latches word bits 11:8 into `reel0_o`, bits 7:4 into `reel1_o` and bits 3:0 into `reel2_o`.
- R5: Code 4'b0010 pulses `is_win_o` and latches word bits 11:0 into `value_o` on the same edge.
- R6: Code 4'b0011 pulses `is_total_o` and latches word bits 11:0 into `value_o` on the same edge.
- R7: Each pulse lasts exactly one system cycle, and at most one of the three pulses is high in any cycle.
- R8: Any other request code produces no pulse and leaves every output unchanged.
- R9: While `rst_ni` is low, all outputs are zero.
- R10: `reel0_o`..`reel2_o` change only together with a `start_spin_o` pulse. `value_o` changes only together with an `is_win_o` or `is_total_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_ni | input | 1 | Active-low select |
| copi_i | input | 1 | Serial data from controller to this block |
| reel0_o | output | 4 | Latched first reel index |
| reel1_o | output | 4 | Latched second reel index |
| reel2_o | output | 4 | Latched third reel index |
| value_o | output | 12 | Latched win amount or credit total |
| start_spin_o | output | 1 | One-cycle spin request pulse |
| is_win_o | output | 1 | One-cycle win-amount pulse |
| is_total_o | output | 1 | One-cycle total-credit pulse |

## Verification
A bit counter that is off by one, or that survives a select release, shows up within one word. The next word decodes as a shifted pattern, so the reel fields and the value carry the wrong nibbles, or the pulse kind changes. A lost or doubled toggle appears a few system cycles after the 16th serial edge, either as a missing pulse or as an extra event that has no matching word. A latch enabled on the wrong code changes `value_o` or a reel output without its pulse. The cycle-by-cycle model catches this on the very edge where it happens.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic [3:0] {
    CMD_SPIN  = 4'h1,
    CMD_WIN   = 4'h2,
    CMD_TOTAL = 4'h3
  } cmd_e;
endpackage

// File: rtl/spi_word_shift.sv
module spi_word_shift #(
  parameter int WORD_W = 16
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              tgl_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] word_q;
  logic              tgl_q;

  // select release clears the bit position at once
  always_ff @(posedge sclk_i or negedge rst_ni or posedge cs_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (cs_ni)          cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_q <= '0;
      tgl_q  <= 1'b0;
    end else if (!cs_ni) begin
      sh_q <= {sh_q[WORD_W-3:0], sdi_i};
      if (cnt_q == LAST) begin
        word_q <= {sh_q, sdi_i};
        tgl_q  <= ~tgl_q;
      end
    end
  end

  assign word_o = word_q;
  assign tgl_o  = tgl_q;

  p_toggle_on_last_r3: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (cnt_q == LAST) |=> (tgl_q != $past(tgl_q)));
  p_hold_mid_word_r1: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (cnt_q != LAST) |=> ($stable(tgl_q) && $stable(word_q)));
endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int DATA_W  = 12,
  parameter int REEL_W  = 4,
  parameter int N_REELS = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             tgl_i,
  input  logic [CODE_W+DATA_W-1:0]         word_i,
  output logic [N_REELS-1:0][REEL_W-1:0]   reels_o,
  output logic [DATA_W-1:0]                value_o,
  output logic                             start_spin_o,
  output logic                             is_win_o,
  output logic                             is_total_o
);
  localparam int WORD_W = CODE_W + DATA_W;

  logic tgl_d_q;
  logic evt;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] payload;
  logic [N_REELS-1:0][REEL_W-1:0] reels_nxt;

  assign evt     = tgl_i ^ tgl_d_q;
  assign code    = word_i[WORD_W-1 -: CODE_W];
  assign payload = word_i[DATA_W-1:0];

  // first reel takes the top field of the payload
  for (genvar i = 0; i < N_REELS; i++) begin : g_field
    assign reels_nxt[i] = payload[DATA_W-1-i*REEL_W -: REEL_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d_q      <= 1'b0;
      reels_o      <= '0;
      value_o      <= '0;
      start_spin_o <= 1'b0;
      is_win_o     <= 1'b0;
      is_total_o   <= 1'b0;
    end else begin
      tgl_d_q      <= tgl_i;
      start_spin_o <= 1'b0;
      is_win_o     <= 1'b0;
      is_total_o   <= 1'b0;
      if (evt) begin
        case (code)
          CMD_SPIN: begin
            start_spin_o <= 1'b1;
            reels_o      <= reels_nxt;
          end
          CMD_WIN: begin
            is_win_o <= 1'b1;
            value_o  <= payload;
          end
          CMD_TOTAL: begin
            is_total_o <= 1'b1;
            value_o    <= payload;
          end
          default: ;
        endcase
      end
    end
  end

  p_onehot_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_spin_o, is_win_o, is_total_o}));
  p_single_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_spin_o || is_win_o || is_total_o) |=> !(start_spin_o || is_win_o || is_total_o));
  p_reel_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_spin_o |-> $stable(reels_o));
  p_value_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(is_win_o || is_total_o) |-> $stable(value_o));
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int CODE_W      = 4,
  parameter int DATA_W      = 12,
  parameter int REEL_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              copi_i,
  output logic [REEL_W-1:0] reel0_o,
  output logic [REEL_W-1:0] reel1_o,
  output logic [REEL_W-1:0] reel2_o,
  output logic [DATA_W-1:0] value_o,
  output logic              start_spin_o,
  output logic              is_win_o,
  output logic              is_total_o
);
  localparam int WORD_W  = CODE_W + DATA_W;
  localparam int N_REELS = 3;

  logic [WORD_W-1:0]              word;
  logic                           tgl_s, tgl_y;
  logic [N_REELS-1:0][REEL_W-1:0] reels;

  spi_word_shift #(.WORD_W(WORD_W)) u_shift (
    .sclk_i (sclk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .sdi_i  (copi_i),
    .word_o (word),
    .tgl_o  (tgl_s)
  );

  bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tgl_s),
    .q_o    (tgl_y)
  );

  // word stays put in its register until the following word completes
  cmd_decode #(
    .CODE_W  (CODE_W),
    .DATA_W  (DATA_W),
    .REEL_W  (REEL_W),
    .N_REELS (N_REELS)
  ) u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgl_i        (tgl_y),
    .word_i       (word),
    .reels_o      (reels),
    .value_o      (value_o),
    .start_spin_o (start_spin_o),
    .is_win_o     (is_win_o),
    .is_total_o   (is_total_o)
  );

  assign reel0_o = reels[0];
  assign reel1_o = reels[1];
  assign reel2_o = reels[2];
endmodule

// File: tb/spi_cmd_rx_test.sv
module spi_cmd_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic copi = 1'b0;
  logic [3:0] reel0, reel1, reel2;
  logic [11:0] value;
  logic start_spin, is_win, is_total;

  always #4 clk = ~clk;

  spi_cmd_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .copi_i(copi),
    .reel0_o(reel0), .reel1_o(reel1), .reel2_o(reel2), .value_o(value),
    .start_spin_o(start_spin), .is_win_o(is_win), .is_total_o(is_total)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] expq[$];
  logic [3:0]  m_r0 = '0, m_r1 = '0, m_r2 = '0;
  logic [11:0] m_val = '0;
  bit run_chk = 0;
  int np, prev_np = 0;
  logic [15:0] w_pop;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, evaluated between clock edges
  always @(negedge clk) begin
    if (run_chk) begin
      np = int'(start_spin) + int'(is_win) + int'(is_total);
      chk(np <= 1, "R7", "pulses at once", np, 1);
      chk(!(np > 0 && prev_np > 0), "R7", "pulse width", prev_np, 0);
      if (np > 0) begin
        if (expq.size() == 0) begin
          chk(0, "R8", "pulse with no valid word", np, 0);
        end else begin
          w_pop = expq.pop_front();
          case (w_pop[15:12])
            4'h1: begin
              chk(start_spin == 1'b1, "R4", "start_spin", start_spin, 1);
              m_r0 = w_pop[11:8]; m_r1 = w_pop[7:4]; m_r2 = w_pop[3:0];
            end
            4'h2: begin
              chk(is_win == 1'b1, "R5", "is_win", is_win, 1);
              m_val = w_pop[11:0];
            end
            default: begin
              chk(is_total == 1'b1, "R6", "is_total", is_total, 1);
              m_val = w_pop[11:0];
            end
          endcase
        end
      end
      prev_np = np;
      chk(reel0 == m_r0, "R4", "reel0", reel0, m_r0);
      chk(reel1 == m_r1, "R4", "reel1", reel1, m_r1);
      chk(reel2 == m_r2, "R4", "reel2", reel2, m_r2);
      chk(value == m_val, "R10", "value", value, m_val);
    end
  end

  task automatic shift_bits(input logic [15:0] w, input int n, input bit sel);
    if (sel) cs_n = 1'b0;
    #30;
    for (int i = 0; i < n; i++) begin
      copi = w[15-i];
      #20 sclk = 1'b1;
      #20 sclk = 1'b0;
    end
    #30 cs_n = 1'b1;
    #20;
  endtask

  task automatic send(input logic [15:0] w);
    if (w[15:12] inside {4'h1, 4'h2, 4'h3}) expq.push_back(w);
    shift_bits(w, 16, 1'b1);
    repeat (6) @(posedge clk);
    #1 chk(expq.size() == 0, "R3", "event not seen in time", expq.size(), 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 outputs at reset
    chk({reel0, reel1, reel2, value, start_spin, is_win, is_total} == '0,
        "R9", "reset outputs", {reel0, reel1, reel2, value}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_chk = 1;

    send(16'h15A3);                 // R1 R4
    send(16'h2123);                 // R5
    send(16'h3FFF);                 // R6
    send(16'h0ABC);                 // R8
    send(16'h4555);                 // R8
    send(16'hF123);                 // R8
    send(16'h1000);                 // R4 all zero fields
    send(16'h1FFF);                 // R4 all ones fields
    shift_bits(16'h2777, 7, 1'b1);  // R2 partial word
    send(16'h2468);                 // R2 next word intact
    shift_bits(16'h3999, 16, 1'b0); // R2 clocks while deselected
    send(16'h3001);                 // R6
    for (int i = 0; i < 15; i++)
      send({4'(i % 5), 12'(i * 12'h151 + 7)});
    send(16'h1C96);
    send(16'h2800);

    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R3", "left-over events", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule